// File: doc/BRIEF.md
# DRAM refresh and power-up sequencer

This block keeps an asynchronous DRAM alive. After reset it holds the strobes idle through a power-up pause. It then runs a fixed number of wake-up refresh cycles before it reports the memory as usable. From then on it issues one CAS-before-RAS refresh per refresh interval. In that kind of refresh the device supplies the row address from its own counter, so no address or data pins are involved. The sequencer shares the strobes with an access controller through a request/grant handshake. It drives the row and column strobes only while it holds the grant.

All timing is set by parameters in nanoseconds together with the clock period in picoseconds. Each duration becomes a cycle count N = ceil(ns * 1000 / CLK_PERIOD_PS). A refresh that cannot be granted is deferred and counted. If the interval timer expires while the deferral count already stands at its limit, the refresh deadline is considered lost. In that case the block raises a sticky overrun flag, discards the deferred refreshes, drops ready and repeats the whole wake-up sequence.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, ras_n and cas_n are 1, and ref_req, ready and overrun are 0.
- R2: ref_req stays low through the pause. It first goes high on the (PAUSE_CYC+1)-th rising clock edge after reset is released.
- R3: ready goes high only after exactly WAKE_COUNT refresh cycles have completed. It rises on the same edge on which ref_req falls at the end of the last of those cycles.
- R4: In every refresh cycle, cas_n falls while ras_n is high. ras_n falls after cas_n has been low for exactly LEAD_CYC cycles, and cas_n is still low when it does.
- R5: ras_n stays low for exactly ACT_CYC cycles. ras_n and cas_n rise on the same edge. Both then stay high for exactly PRE_CYC cycles before ref_req falls.
- R6: A refresh cycle starts (cas_n falls) only on the edge after one at which ref_req and ref_gnt were both high. While ref_gnt is withheld, ras_n shows no falling edge.
- R7: In normal operation, a grant given without delay makes successive falling edges of ras_n exactly REFI_CYC cycles apart. Over a window of k intervals with short grant delays, exactly k refreshes are issued.
- R8: While the grant is withheld, up to DEFER_LIMIT refreshes are kept pending. Once the grant returns, every pending refresh is issued back to back.
- R9: Suppose the interval timer expires with DEFER_LIMIT refreshes already pending and no refresh finishing. Then overrun becomes 1 and ready becomes 0. The pending count is discarded, and exactly WAKE_COUNT refresh cycles complete before ready returns to 1.
- R10: Once set, overrun stays 1 until reset, through the repeated wake-up sequence and later normal operation. Reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Grant from the access controller; it must stay high until ref_req falls |
| ref_req | output | 1 | Request for the strobes; it is held from request until the end of precharge |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| ready | output | 1 | High once the power-up or recovery wake-up sequence has finished |
| overrun | output | 1 | Sticky flag: a refresh deadline was lost |

## Verification
Most wrong internal states show up within one refresh cycle as a strobe edge out of place. A wrong phase counter in the strobe engine moves a strobe edge, which the per-cycle checks of the lead, active and precharge widths catch within about 25 cycles. A wrong interval timer or deferral count only becomes visible later. It shows as a wrong spacing between falling edges of ras_n, or as the wrong number of refreshes after the grant returns, so it is detected one to five refresh intervals after the fault. A faulty pause or wake-up counter changes the edge on which the first request appears, or the number of refreshes seen before ready rises.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [1:0] {
        M_PAUSE,
        M_WAKE,
        M_RUN
    } seq_mode_e;

    typedef enum logic [2:0] {
        E_IDLE,
        E_WAIT,
        E_LEAD,
        E_ACT,
        E_PRE
    } cbr_phase_e;

    // Convert a duration in ns into whole clock cycles, rounding up, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ps);
        int unsigned c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int unsigned PERIOD = 3907
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned TW = $clog2(PERIOD + 1);
    localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: the interval counter never passes its terminal value
    a_r7_timer_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R7: while running, a tick is followed by a fresh interval
    a_r7_restart_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run) |=> (cnt_q == '0));

endmodule

// File: rtl/ref_defer_counter.sv
module ref_defer_counter #(
    parameter int unsigned LIMIT = 4,
    localparam int unsigned PW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          dec,
    input  logic          clr,
    output logic [PW-1:0] pending,
    output logic          ovf
);
    localparam logic [PW-1:0] FULL = PW'(LIMIT);

    logic [PW-1:0] pend_d, pend_q;

    always_comb begin
        ovf    = tick && !dec && (pend_q == FULL);
        pend_d = pend_q;
        if (clr || ovf) begin
            pend_d = '0;
        end else if (tick && !dec) begin
            pend_d = pend_q + PW'(1);
        end else if (dec && !tick) begin
            pend_d = pend_q - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pending = pend_q;

    // R8: the backlog never exceeds its limit
    a_r8_backlog_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= FULL);

    // R8: a completed refresh is only credited against an existing backlog
    a_r8_dec_needs_backlog: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (pend_q != '0));

    // R9: a lost deadline empties the backlog
    a_r9_ovf_discards: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (pend_q == '0));

endmodule

// File: rtl/ref_cbr_engine.sv
module ref_cbr_engine
    import dram_ref_pkg::*;
#(
    parameter int unsigned LEAD_CYC = 2,
    parameter int unsigned ACT_CYC  = 13,
    parameter int unsigned PRE_CYC  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic gnt,
    output logic req,
    output logic ras_n,
    output logic cas_n,
    output logic done
);
    localparam int unsigned SPAN0 = (LEAD_CYC > ACT_CYC) ? LEAD_CYC : ACT_CYC;
    localparam int unsigned SPAN  = (SPAN0 > PRE_CYC) ? SPAN0 : PRE_CYC;
    localparam int unsigned CW    = $clog2(SPAN + 1);
    localparam logic [CW-1:0] LEAD_LD = CW'(LEAD_CYC - 1);
    localparam logic [CW-1:0] ACT_LD  = CW'(ACT_CYC - 1);
    localparam logic [CW-1:0] PRE_LD  = CW'(PRE_CYC - 1);

    typedef struct packed {
        cbr_phase_e    phase;
        logic [CW-1:0] cnt;
        logic          req;
        logic          ras_n;
        logic          cas_n;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        done  = 1'b0;
        unique case (eng_q.phase)
            E_IDLE: begin
                if (want) begin
                    eng_d.req   = 1'b1;
                    eng_d.phase = E_WAIT;
                end
            end
            E_WAIT: begin
                if (gnt) begin
                    eng_d.phase = E_LEAD;
                    eng_d.cas_n = 1'b0;
                    eng_d.cnt   = LEAD_LD;
                end
            end
            E_LEAD: begin
                if (eng_q.cnt == '0) begin
                    eng_d.phase = E_ACT;
                    eng_d.ras_n = 1'b0;
                    eng_d.cnt   = ACT_LD;
                end else begin
                    eng_d.cnt = eng_q.cnt - CW'(1);
                end
            end
            E_ACT: begin
                if (eng_q.cnt == '0) begin
                    eng_d.phase = E_PRE;
                    eng_d.ras_n = 1'b1;
                    eng_d.cas_n = 1'b1;
                    eng_d.cnt   = PRE_LD;
                end else begin
                    eng_d.cnt = eng_q.cnt - CW'(1);
                end
            end
            E_PRE: begin
                if (eng_q.cnt == '0) begin
                    done        = 1'b1;
                    eng_d.req   = 1'b0;
                    eng_d.phase = E_IDLE;
                end else begin
                    eng_d.cnt = eng_q.cnt - CW'(1);
                end
            end
            default: begin
                eng_d.phase = E_IDLE;
                eng_d.req   = 1'b0;
                eng_d.ras_n = 1'b1;
                eng_d.cas_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{phase: E_IDLE, cnt: '0, req: 1'b0, ras_n: 1'b1, cas_n: 1'b1};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign req   = eng_q.req;
    assign ras_n = eng_q.ras_n;
    assign cas_n = eng_q.cas_n;

    // R4: the row strobe only falls while the column strobe was already low
    a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && !$past(cas_n)));

    // R4: the column strobe falls with the row strobe high
    a_r4_cas_falls_ras_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> (ras_n && $past(ras_n)));

    // R5: both strobes are released together
    a_r5_joint_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> $rose(cas_n));

    // R6: a refresh starts only after request and grant were seen together
    a_r6_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> ($past(gnt) && $past(req)));

    // R5: the request is withdrawn only with both strobes high
    a_r5_req_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> (ras_n && cas_n));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_ref_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 4000,
    parameter int unsigned PAUSE_NS      = 200000,
    parameter int unsigned REFI_NS       = 15625,
    parameter int unsigned TRAS_NS       = 50,
    parameter int unsigned TRP_NS        = 30,
    parameter int unsigned TCSR_NS       = 5,
    parameter int unsigned WAKE_COUNT    = 8,
    parameter int unsigned DEFER_LIMIT   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ras_n,
    output logic cas_n,
    output logic ready,
    output logic overrun
);
    localparam int unsigned PAUSE_CYC = ns_to_cyc(PAUSE_NS, CLK_PERIOD_PS);
    localparam int unsigned REFI_CYC  = ns_to_cyc(REFI_NS, CLK_PERIOD_PS);
    localparam int unsigned ACT_CYC   = ns_to_cyc(TRAS_NS, CLK_PERIOD_PS);
    localparam int unsigned PRE_CYC   = ns_to_cyc(TRP_NS, CLK_PERIOD_PS);
    localparam int unsigned LEAD_CYC  = ns_to_cyc(TCSR_NS, CLK_PERIOD_PS);
    localparam int unsigned PCW       = $clog2(PAUSE_CYC + 1);
    localparam int unsigned WW        = $clog2(WAKE_COUNT + 1);
    localparam int unsigned PW        = $clog2(DEFER_LIMIT + 1);
    localparam logic [PCW-1:0] PAUSE_LAST = PCW'(PAUSE_CYC - 1);
    localparam logic [WW-1:0]  WAKE_LD    = WW'(WAKE_COUNT);

    typedef struct packed {
        seq_mode_e      mode;
        logic [PCW-1:0] pcnt;
        logic [WW-1:0]  wake_left;
        logic           ready;
        logic           overrun;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          run;
    logic          tick;
    logic          want;
    logic          done;
    logic          ovf;
    logic [PW-1:0] pending;

    assign run  = (seq_q.mode == M_RUN);
    assign want = ((seq_q.mode == M_WAKE) && (seq_q.wake_left != '0)) ||
                  (run && (pending != '0));

    ref_interval_timer #(
        .PERIOD(REFI_CYC)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    ref_defer_counter #(
        .LIMIT(DEFER_LIMIT)
    ) u_defer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .dec    (done && run),
        .clr    (!run),
        .pending(pending),
        .ovf    (ovf)
    );

    ref_cbr_engine #(
        .LEAD_CYC(LEAD_CYC),
        .ACT_CYC (ACT_CYC),
        .PRE_CYC (PRE_CYC)
    ) u_engine (
        .clk  (clk),
        .rst_n(rst_n),
        .want (want),
        .gnt  (ref_gnt),
        .req  (ref_req),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .done (done)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.mode)
            M_PAUSE: begin
                if (seq_q.pcnt == PAUSE_LAST) begin
                    seq_d.mode      = M_WAKE;
                    seq_d.pcnt      = '0;
                    seq_d.wake_left = WAKE_LD;
                end else begin
                    seq_d.pcnt = seq_q.pcnt + PCW'(1);
                end
            end
            M_WAKE: begin
                if (done) begin
                    if (seq_q.wake_left == WW'(1)) begin
                        seq_d.mode      = M_RUN;
                        seq_d.ready     = 1'b1;
                        seq_d.wake_left = '0;
                    end else begin
                        seq_d.wake_left = seq_q.wake_left - WW'(1);
                    end
                end
            end
            M_RUN: begin
                if (ovf) begin
                    seq_d.mode      = M_WAKE;
                    seq_d.wake_left = WAKE_LD;
                    seq_d.ready     = 1'b0;
                    seq_d.overrun   = 1'b1;
                end
            end
            default: begin
                seq_d.mode  = M_PAUSE;
                seq_d.pcnt  = '0;
                seq_d.ready = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{mode: M_PAUSE, pcnt: '0, wake_left: '0, ready: 1'b0, overrun: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready   = seq_q.ready;
    assign overrun = seq_q.overrun;

    // R2: nothing is requested or strobed during the power-up pause
    a_r2_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.mode == M_PAUSE) |-> (!ref_req && ras_n && cas_n));

    // R3: ready rises together with the end of the final wake-up request
    a_r3_ready_with_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $fell(ref_req));

    // R9: a lost deadline drops ready and raises the flag on the next edge
    a_r9_ovf_reaction: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (!ready && overrun));

    // R10: the overrun flag never clears outside reset
    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;

    localparam int unsigned CLK_PS   = 4000;
    localparam int unsigned PAUSE_NS = 2000;
    localparam int unsigned REFI_NS  = 1000;
    localparam int unsigned TRAS_NS  = 50;
    localparam int unsigned TRP_NS   = 30;
    localparam int unsigned TCSR_NS  = 5;
    localparam int          WAKE     = 8;
    localparam int          LIMIT    = 3;

    function automatic int cyc_of(input int unsigned ns);
        int c;
        c = int'((ns * 1000 + CLK_PS - 1) / CLK_PS);
        return (c < 1) ? 1 : c;
    endfunction

    localparam int NPAUSE = cyc_of(PAUSE_NS);
    localparam int NREFI  = cyc_of(REFI_NS);
    localparam int NRAS   = cyc_of(TRAS_NS);
    localparam int NRP    = cyc_of(TRP_NS);
    localparam int NCSR   = cyc_of(TCSR_NS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0;
    logic req, ras_n, cas_n, ready, overrun;

    always #2 clk = ~clk;

    dram_refresh_seq #(
        .CLK_PERIOD_PS(CLK_PS),
        .PAUSE_NS     (PAUSE_NS),
        .REFI_NS      (REFI_NS),
        .TRAS_NS      (TRAS_NS),
        .TRP_NS       (TRP_NS),
        .TCSR_NS      (TCSR_NS),
        .WAKE_COUNT   (WAKE),
        .DEFER_LIMIT  (LIMIT)
    ) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_gnt(gnt),
        .ref_req(req),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .ready  (ready),
        .overrun(overrun)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (t=%0t)", r, act, exp, $time);
        end
    endtask

    // Grant driver: answers requests after a random delay unless held off.
    int unsigned max_dly = 0;
    int unsigned dly = 0;
    int unsigned wait_cnt = 0;
    bit hold = 1'b0;

    always @(posedge clk) begin
        #1;
        if (!rst_n || !req) begin
            gnt      = 1'b0;
            wait_cnt = 0;
            dly      = (max_dly > 0) ? $urandom_range(max_dly, 0) : 0;
        end else if (!gnt && !hold) begin
            if (wait_cnt >= dly) gnt = 1'b1;
            else                 wait_cnt++;
        end
    end

    // Strobe monitor, sampled at the falling clock edge.
    int cyc = 0, ras_falls = 0, cas_low_run = 0, ras_low_run = 0, ras_high_run = 0;
    int last_fall_cyc = 0, last_gap = 0;
    logic p_ras = 1'b1, p_cas = 1'b1, p_req = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; ras_falls = 0; cas_low_run = 0; ras_low_run = 0; ras_high_run = 0;
            last_fall_cyc = 0; last_gap = 0;
            p_ras = 1'b1; p_cas = 1'b1; p_req = 1'b0;
        end else begin
            cyc++;
            if (p_cas && !cas_n) begin
                chk(p_ras && ras_n, "R4 cas falls with ras high", int'({p_ras, ras_n}), 3);
                chk(gnt && p_req, "R6 start needs req and grant", int'({gnt, p_req}), 3);
            end
            if (p_ras && !ras_n) begin
                ras_falls++;
                chk(cas_low_run == NCSR && !cas_n, "R4 cas lead cycles", cas_low_run, NCSR);
                last_gap      = cyc - last_fall_cyc;
                last_fall_cyc = cyc;
            end
            if (!p_ras && ras_n) begin
                chk(ras_low_run == NRAS, "R5 ras low width", ras_low_run, NRAS);
                chk(cas_n == 1'b1, "R5 joint release", int'(cas_n), 1);
            end
            if (p_req && !req) begin
                chk(ras_high_run == NRP, "R5 precharge width", ras_high_run, NRP);
            end
            cas_low_run  = cas_n ? 0 : cas_low_run + 1;
            ras_low_run  = ras_n ? 0 : ras_low_run + 1;
            ras_high_run = ras_n ? ras_high_run + 1 : 0;
            p_ras = ras_n; p_cas = cas_n; p_req = req;
        end
    end

    task automatic tick_n(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wait_falls(input int n);
        int start;
        int guard;
        start = ras_falls;
        guard = 0;
        while (ras_falls < start + n && guard < 4 * NREFI) begin
            tick_n(1);
            guard++;
        end
        chk(ras_falls >= start + n, "R7 refresh keeps coming", ras_falls - start, n);
    endtask

    task automatic wait_ready(input int limit);
        int guard;
        guard = 0;
        while (!ready && guard < limit) begin
            tick_n(1);
            guard++;
        end
        chk(ready == 1'b1, "R3 ready reached", int'(ready), 1);
    endtask

    task automatic check_reset_state(input string r);
        chk(ras_n == 1'b1 && cas_n == 1'b1, r, int'({ras_n, cas_n}), 3);
        chk(req == 1'b0 && ready == 1'b0, r, int'({req, ready}), 0);
        chk(overrun == 1'b0, r, int'(overrun), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        int cnt;
        int start;
        int k;
        seed = $urandom(32'd4242);

        // R1: outputs while reset is held
        tick_n(3);
        check_reset_state("R1 reset state");

        // R2: pause length before the first request
        rst_n = 1'b1;
        cnt = 0;
        do begin
            tick_n(1);
            cnt++;
            if (!req) chk(ready == 1'b0, "R2 ready low in pause", int'(ready), 0);
        end while (!req && cnt < NPAUSE + 10);
        chk(cnt == NPAUSE + 1, "R2 first request edge", cnt, NPAUSE + 1);

        // R3: wake-up count before ready
        wait_ready(20 * NREFI);
        chk(ras_falls == WAKE, "R3 wake-up refresh count", ras_falls, WAKE);
        chk(req == 1'b0, "R3 req falls with ready", int'(req), 0);

        // R7: exact spacing with immediate grant
        max_dly = 0;
        wait_falls(1);
        for (int i = 0; i < 2; i++) begin
            wait_falls(1);
            chk(last_gap == NREFI, "R7 refresh spacing", last_gap, NREFI);
        end

        // R7: random grant delays, one refresh per interval
        max_dly = 7;
        for (int i = 0; i < 2; i++) begin
            wait_falls(1);
            start = ras_falls;
            tick_n(8 * NREFI + 20);
            chk(ras_falls - start == 8, "R7 refreshes per window", ras_falls - start, 8);
            chk(ready == 1'b1 && overrun == 1'b0, "R7 stays ready", int'({ready, overrun}), 2);
        end

        // R8 and R6: random deferrals within the limit
        max_dly = 0;
        for (int r = 0; r < 4; r++) begin
            k = int'($urandom_range(LIMIT, 1));
            wait_falls(1);
            hold  = 1'b1;
            start = ras_falls;
            tick_n(k * NREFI + NREFI / 2);
            chk(ras_falls == start, "R6 no refresh while withheld", ras_falls - start, 0);
            hold = 1'b0;
            tick_n(100);
            chk(ras_falls - start == k, "R8 deferred refreshes issued", ras_falls - start, k);
            chk(overrun == 1'b0 && ready == 1'b1, "R8 no overrun within limit", int'({overrun, ready}), 1);
        end

        // R9: deadline lost after the limit is exceeded
        wait_falls(1);
        hold  = 1'b1;
        start = ras_falls;
        tick_n((LIMIT + 2) * NREFI);
        chk(ras_falls == start, "R6 no refresh while withheld", ras_falls - start, 0);
        chk(overrun == 1'b1, "R9 overrun raised", int'(overrun), 1);
        chk(ready == 1'b0, "R9 ready dropped", int'(ready), 0);
        hold = 1'b0;
        wait_ready(20 * NREFI);
        chk(ras_falls - start == WAKE, "R9 wake-up repeated", ras_falls - start, WAKE);

        // R10: sticky through further operation, cleared by reset
        tick_n(2 * NREFI);
        chk(overrun == 1'b1, "R10 overrun sticky", int'(overrun), 1);
        chk(ready == 1'b1, "R10 ready after recovery", int'(ready), 1);
        rst_n = 1'b0;
        tick_n(3);
        check_reset_state("R10 reset clears overrun");
        rst_n = 1'b1;
        tick_n(NPAUSE / 2);
        chk(req == 1'b0 && ready == 1'b0, "R2 quiet after second reset", int'({req, ready}), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule